// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block steps through the column addresses of a single SDRAM read or write burst. A controller pulses a start strobe together with the first column, a burst length code and an ordering bit. From the next clock on, the block presents one column address per cycle with a valid flag, and it raises a last flag on the final beat of a fixed-length burst.

Bursts of 1, 2, 4 and 8 beats change only the low column bits and leave the upper bits at the starting value. Those low bits either count upward with wrap-around (sequential order) or are the starting bits XORed with the beat number (interleaved order). In full-page mode the whole 9-bit column counts upward modulo 512 and keeps running until a burst-stop strobe or a new start arrives. A new start may follow on any cycle, including the cycle of a running burst's last beat, so bursts can run back to back.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, colValid and colLast are 0 until the first start strobe.
- R2: A start strobe sampled at a clock edge makes colValid 1 and colOut equal to the sampled startCol right after that edge (beat 0).
- R3: lenCode selects the burst length: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives full page. A fixed-length burst shows exactly that many consecutive valid beats, then colValid drops unless a new start arrives.
- R4: In sequential order (interleave = 0) with length L = 2^n, beat k shows the upper 9-n bits of startCol unchanged and the low n bits equal to (startCol + k) mod L.
- R5: In interleaved order (interleave = 1) with length L, beat k shows startCol XOR k, where k < L only touches the low n bits.
- R6: In full-page mode, beat k shows (startCol + k) mod 512, wrapping from 511 to 0, and the burst has no end of its own. The interleave input has no effect in this mode.
- R7: colLast is 1 exactly on the final beat of a fixed-length burst (beat 0 for length 1) and is never 1 in full-page mode.
- R8: A stop strobe sampled with colValid 1 and no start strobe makes colValid 0 after that edge. A stop strobe while idle has no effect.
- R9: A start strobe during a running burst restarts the sequence from the new startCol at the next beat. A start takes priority over a stop in the same cycle.
- R10: The reserved length codes 3'b100, 3'b101 and 3'b110 behave as a burst of one beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| startStb | input | 1 | Begins a new burst with the inputs sampled at this edge |
| stopStb | input | 1 | Ends the running burst |
| startCol | input | 9 | First column of the burst |
| lenCode | input | 3 | Burst length code (see R3) |
| interleave | input | 1 | 1 selects interleaved order, 0 sequential |
| colOut | output | 9 | Column address of the current beat |
| colValid | output | 1 | colOut holds a beat of a burst |
| colLast | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
The assertions check on every cycle that a start is followed by a valid beat at the sampled column, that colLast only appears with colValid and never in full-page mode, that a stop without a start clears colValid, and that advancing within a burst never disturbs the column bits outside the burst window. The exact order of beats in sequential, interleaved and full-page modes, the beat count per length code, the 511-to-0 wrap, restarts in mid-burst and the reserved codes can only be shown by the bench's scenarios against its reference sequence.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  localparam logic [2:0] LEN_1    = 3'b000;
  localparam logic [2:0] LEN_2    = 3'b001;
  localparam logic [2:0] LEN_4    = 3'b010;
  localparam logic [2:0] LEN_8    = 3'b011;
  localparam logic [2:0] LEN_FULL = 3'b111;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new burst, beat 0 next
    logic step;   // advance one beat
  } ctrlStrobes_t;

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStb,
  input  logic             stopStb,
  input  logic [2:0]       lenCode,
  output ctrlStrobes_t     strb,
  output logic [COL_W-1:0] newMask,
  output logic             newFull,
  output logic             colValid,
  output logic             colLast
);

  logic             activeQ;
  logic             fullQ;
  logic [COL_W-1:0] leftQ;
  logic             endOfBurst;

  // length decode: mask of the low bits that move during the burst
  always_comb begin
    unique case (lenCode)
      LEN_2:    newMask = COL_W'(1);
      LEN_4:    newMask = COL_W'(3);
      LEN_8:    newMask = COL_W'(7);
      LEN_FULL: newMask = '1;
      default:  newMask = '0;
    endcase
    newFull = (lenCode == LEN_FULL);
  end

  assign endOfBurst = !fullQ && (leftQ == '0);

  always_comb begin
    strb.load = startStb;
    strb.step = activeQ && !startStb && !stopStb && !endOfBurst;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      fullQ   <= 1'b0;
      leftQ   <= '0;
    end else if (startStb) begin
      activeQ <= 1'b1;
      fullQ   <= newFull;
      leftQ   <= newFull ? '0 : newMask;
    end else if (activeQ) begin
      if (stopStb || endOfBurst) begin
        activeQ <= 1'b0;
      end else if (!fullQ) begin
        leftQ <= leftQ - COL_W'(1);
      end
    end
  end

  assign colValid = activeQ;
  assign colLast  = activeQ && endOfBurst;

  // R2
  start_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    startStb |=> colValid);

  // R7
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    colLast |-> colValid);

  // R7
  full_no_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startStb && newFull) |=> !colLast);

  // R8
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopStb && !startStb) |=> !colValid);

  // R3
  last_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    (colLast && !startStb) |=> !colValid);

endmodule

// File: rtl/burst_dp.sv
module burst_dp
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic [COL_W-1:0] startCol,
  input  logic [COL_W-1:0] newMask,
  input  logic             newFull,
  input  logic             interleave,
  output logic [COL_W-1:0] colOut
);

  logic [COL_W-1:0] baseQ;
  logic [COL_W-1:0] offQ;
  logic [COL_W-1:0] maskQ;
  logic             fullQ;
  logic             ilQ;
  logic [COL_W-1:0] seqCol;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      offQ  <= '0;
      maskQ <= '0;
      fullQ <= 1'b0;
      ilQ   <= 1'b0;
    end else if (strb.load) begin
      baseQ <= startCol;
      offQ  <= '0;
      maskQ <= newMask;
      fullQ <= newFull;
      ilQ   <= interleave;
    end else if (strb.step) begin
      offQ  <= offQ + COL_W'(1);
    end
  end

  assign seqCol = baseQ + offQ;

  always_comb begin
    if (fullQ)
      colOut = seqCol;
    else if (ilQ)
      colOut = baseQ ^ (offQ & maskQ);
    else
      colOut = (baseQ & ~maskQ) | (seqCol & maskQ);
  end

  // R2
  load_col_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (colOut == $past(startCol)));

  // R4
  high_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> ((colOut & ~maskQ) == $past(colOut & ~maskQ)));

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStb,
  input  logic             stopStb,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  input  logic             interleave,
  output logic [COL_W-1:0] colOut,
  output logic             colValid,
  output logic             colLast
);

  ctrlStrobes_t     strb;
  logic [COL_W-1:0] newMask;
  logic             newFull;

  burst_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startStb (startStb),
    .stopStb  (stopStb),
    .lenCode  (lenCode),
    .strb     (strb),
    .newMask  (newMask),
    .newFull  (newFull),
    .colValid (colValid),
    .colLast  (colLast)
  );

  burst_dp #(.COL_W(COL_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .startCol   (startCol),
    .newMask    (newMask),
    .newFull    (newFull),
    .interleave (interleave),
    .colOut     (colOut)
  );

endmodule

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startStb = 1'b0;
  logic       stopStb = 1'b0;
  logic [8:0] startCol = '0;
  logic [2:0] lenCode = '0;
  logic       interleave = 1'b0;
  logic [8:0] colOut;
  logic       colValid;
  logic       colLast;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  bit       mActive = 0;
  bit       mFull = 0;
  bit       mIl = 0;
  int       mK = 0;
  int       mLen = 1;
  int       mBase = 0;

  always #5 clk = ~clk;

  burst_col_gen u_burst_col_gen (
    .clk(clk), .rstN(rstN), .startStb(startStb), .stopStb(stopStb),
    .startCol(startCol), .lenCode(lenCode), .interleave(interleave),
    .colOut(colOut), .colValid(colValid), .colLast(colLast)
  );

  function automatic int lenOf(logic [2:0] code);
    case (code)
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return 512;
      default: return 1;
    endcase
  endfunction

  function automatic int expCol();
    int m = mLen - 1;
    if (mFull) return (mBase + mK) % 512;
    if (mIl) return mBase ^ mK;
    return (mBase & ~m & 511) | ((mBase + mK) & m);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, update reference at edge, compare at next negedge
  task automatic cyc(bit st, bit sp, int col, logic [2:0] code, bit il, string tag);
    startStb = st; stopStb = sp; startCol = 9'(col); lenCode = code; interleave = il;
    @(posedge clk);
    if (st) begin
      mActive = 1; mK = 0; mBase = col; mLen = lenOf(code);
      mFull = (code == 3'b111); mIl = il;
    end else if (mActive) begin
      if (sp) mActive = 0;
      else if (!mFull && mK == mLen - 1) mActive = 0;
      else mK = mK + 1;
    end
    @(negedge clk);
    chk({tag, " valid"}, int'(colValid), int'(mActive));
    if (mActive) begin
      chk({tag, " col"}, int'(colOut), expCol());
      chk({tag, " last"}, int'(colLast), int'(!mFull && mK == mLen - 1));
    end else begin
      chk({tag, " last idle"}, int'(colLast), 0);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1
    chk("R1 valid", int'(colValid), 0);
    chk("R1 last", int'(colLast), 0);
    rstN = 1'b1;
    @(negedge clk);
    cyc(0, 0, 0, 0, 0, "R1 idle");

    // R8 stop while idle has no effect
    cyc(0, 1, 0, 0, 0, "R8 idle stop");

    // R2 R3 R4 sequential length 8 wrapping low bits
    cyc(1, 0, 9'h1FD, 3'b011, 0, "R2 start");
    repeat (8) cyc(0, 0, 0, 0, 0, "R4 seq8");

    // R5 interleave length 4
    cyc(1, 0, 9'h0A2, 3'b010, 1, "R5 start");
    repeat (4) cyc(0, 0, 0, 0, 0, "R5 il4");

    // R3 R7 length 2 and 1
    cyc(1, 0, 9'h011, 3'b001, 0, "R3 len2");
    cyc(0, 0, 0, 0, 0, "R7 len2 last");
    cyc(1, 0, 9'h033, 3'b000, 1, "R7 len1");
    cyc(0, 0, 0, 0, 0, "R3 len1 end");

    // R10 reserved codes
    for (int c = 4; c < 7; c++) begin
      cyc(1, 0, 9'h040 + c, 3'(c), 0, "R10 reserved");
      cyc(0, 0, 0, 0, 0, "R10 end");
    end

    // R6 full page from 0x1FE, long run with wrap, interleave ignored
    cyc(1, 0, 9'h1FE, 3'b111, 1, "R6 start");
    repeat (600) cyc(0, 0, 0, 0, 0, "R6 full");
    cyc(0, 1, 0, 0, 0, "R8 stop full");
    cyc(0, 0, 0, 0, 0, "R8 after stop");

    // R9 restart mid burst, start beats stop
    cyc(1, 0, 9'h100, 3'b011, 0, "R9 first");
    cyc(0, 0, 0, 0, 0, "R9 beat");
    cyc(1, 1, 9'h0F7, 3'b010, 1, "R9 restart");
    repeat (4) cyc(0, 0, 0, 0, 0, "R9 run");

    // R9 back to back on last beat
    cyc(1, 0, 9'h005, 3'b001, 0, "R9 b2b a");
    cyc(0, 0, 0, 0, 0, "R9 b2b last");
    cyc(1, 0, 9'h1F0, 3'b001, 1, "R9 b2b b");
    cyc(0, 0, 0, 0, 0, "R9 b2b end");

    // R8 stop mid fixed burst
    cyc(1, 0, 9'h020, 3'b011, 0, "R8 start");
    cyc(0, 0, 0, 0, 0, "R8 beat");
    cyc(0, 1, 0, 0, 0, "R8 stop");

    // random mix, R3 R4 R5 R6 R7
    for (int i = 0; i < 4000; i++) begin
      bit st = ($urandom_range(5) == 0);
      bit sp = ($urandom_range(19) == 0);
      cyc(st, sp, int'($urandom_range(511)), 3'($urandom_range(7)),
          1'($urandom_range(1)), "R4 R5 R6 R7 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule